// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the small register window of a shared-memory device that links several compute nodes. Software uses it to mask and acknowledge a 32-bit bank of interrupt causes, to learn its own node number, and to ring a doorbell on another node. The block drives one level interrupt. That line is high while any unmasked cause bit is set. An event port lets the notification path load a cause byte straight into the status bank.

A doorbell is one 32-bit write that packs the target node into the upper half-word and the vector into the low byte. The block checks the target against the number of nodes currently known. It then checks the vector against the number of vectors that node has offered. Only a doorbell that passes both checks leaves as a one-cycle pulse with the target and vector registered beside it. Reading the status bank hands back its value and empties it in the same access, so the read doubles as the acknowledge.

Top module: `dbell_regs`

## Requirements
- R1: After reset the mask and status banks read 0, the interrupt is low, the read data bus is 0 and no doorbell pulse is present.
- R2: A write to byte offset 0x00 replaces the whole 32-bit mask. The low two address bits are ignored, so offsets 0x01 to 0x03 also reach the mask.
- R3: The interrupt output is high exactly when the bitwise AND of status and mask is nonzero. It follows a mask or status change on the clock edge that stores the change.
- R4: A read of offset 0x04 returns the status value held before the read and sets status to 0 on the same edge, which may drop the interrupt.
- R5: A write to offset 0x04 replaces all 32 status bits with the written word.
- R6: An event byte loads status as that byte zero-extended to 32 bits. When a status read or a status write falls in the same cycle, the event wins and is kept.
- R7: A read of offset 0x08 returns the local node ID zero-extended while the shared memory is flagged as mapped, and 0xFFFFFFFF otherwise.
- R8: A doorbell write to offset 0x0C is dropped when the destination (bits 31:16) is not below the peer count input, or not below the table size NUM_PEERS.
- R9: A doorbell that passes the checks raises the pulse output for exactly one cycle, on the edge after the write. The destination and vector (bits 7:0) are held on their outputs. Bits 15:8 of the written word are ignored.
- R10: A doorbell is dropped when its vector is not below the vector count of its destination. Peer p's count sits in bits 8p+7 to 8p of the vector-count table input.
- R11: Reads of unmapped offsets return 0. Writes to offset 0x08 and to unmapped offsets change neither mask nor status.
- R12: Read data is registered. It appears on the clock edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address within the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| evt_valid | input | 1 | Event byte present |
| evt_byte | input | 8 | Event byte written into status |
| shm_mapped | input | 1 | Shared memory currently mapped |
| node_id | input | 16 | Local node number |
| peer_cnt | input | 3 | Number of peers currently known |
| vec_cnt | input | 32 | Per-peer vector counts, 8 bits per peer |
| ring_pulse | output | 1 | One-cycle doorbell notification |
| ring_dest | output | 16 | Destination peer of the last doorbell |
| ring_vec | output | 8 | Vector of the last doorbell |

## Verification
The hardest case to reach is an event byte that lands on the same clock edge as a status read or a status write. The read must return the old value while the event survives the clear. The stimulus first loads a known pattern into status. It then raises the event strobe in the very cycle that carries the read strobe, and again in the cycle that carries a bus write. A second read then shows that the event byte, not zero and not the bus word, was kept. Doorbell range checks are reached through a vector table with one empty peer, and through a peer count smaller than the table size.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_POS  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RING = 8'h0C;
  localparam logic [ADDR_W-1:0] WORD_MSK = 8'hFC;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2,
    SEL_POS  = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic wr_mask;
    logic wr_stat;
    logic rd_stat;
    logic wr_ring;
  } acc_t;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
(
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc,
  output rd_sel_e           rd_sel
);

  logic [ADDR_W-1:0] word;

  always_comb begin
    word   = addr & WORD_MSK;
    acc    = '0;
    rd_sel = SEL_NONE;
    unique case (word)
      OFS_MASK: begin
        acc.wr_mask = wr;
        rd_sel      = SEL_MASK;
      end
      OFS_STAT: begin
        acc.wr_stat = wr;
        acc.rd_stat = rd;
        rd_sel      = SEL_STAT;
      end
      OFS_POS: begin
        rd_sel = SEL_POS;
      end
      OFS_RING: begin
        acc.wr_ring = wr;
      end
      default: begin
        rd_sel = SEL_NONE;
      end
    endcase
  end

endmodule

// File: rtl/dbell_irq.sv
module dbell_irq
  import dbell_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt_valid,
  input  logic [EVT_W-1:0]  evt_byte,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq
);

  localparam int PAD_W = DATA_W - EVT_W;

  logic [DATA_W-1:0] mask_d;
  logic [DATA_W-1:0] stat_d;
  logic              mask_en;
  logic              stat_en;
  logic [DATA_W-1:0] evt_word;

  assign evt_word = {{PAD_W{1'b0}}, evt_byte};

  always_comb begin
    mask_en = wr_mask;
    mask_d  = wdata;
  end

  always_comb begin
    stat_en = rd_stat | wr_stat | evt_valid;
    stat_d  = stat_q;
    if (rd_stat)   stat_d = '0;
    if (wr_stat)   stat_d = wdata;
    if (evt_valid) stat_d = evt_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  assign irq = |(stat_q & mask_q);

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wr_stat && !evt_valid) |=> (stat_q == '0)); // R4

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (stat_q == {{PAD_W{1'b0}}, $past(evt_byte)})); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R11

endmodule

// File: rtl/dbell_ring.sv
module dbell_ring #(
  parameter int NUM_PEERS = 4,
  parameter int DEST_W    = 16,
  parameter int VEC_W     = 8,
  parameter int PCNT_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ring,
  input  logic [DEST_W-1:0]          dest_in,
  input  logic [VEC_W-1:0]           vec_in,
  input  logic [PCNT_W-1:0]          peer_cnt,
  input  logic [NUM_PEERS*VEC_W-1:0] vec_cnt,
  output logic                       ring_pulse,
  output logic [DEST_W-1:0]          ring_dest,
  output logic [VEC_W-1:0]           ring_vec
);

  localparam int IDX_W = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1;
  localparam int CMP_W = DEST_W + 1;
  localparam logic [CMP_W-1:0] TAB_LIM = CMP_W'(NUM_PEERS);

  logic [VEC_W-1:0] cnt_arr [NUM_PEERS];

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_unpack
    assign cnt_arr[p] = vec_cnt[p*VEC_W +: VEC_W];
  end

  logic [CMP_W-1:0] dest_ext;
  logic [CMP_W-1:0] pcnt_ext;
  logic             dest_ok;
  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] sel_cnt;
  logic             vec_ok;
  logic             fire;
  logic             pulse_d;
  logic             hold_en;

  always_comb begin
    dest_ext = {1'b0, dest_in};
    pcnt_ext = CMP_W'(peer_cnt);
    dest_ok  = (dest_ext < pcnt_ext) && (dest_ext < TAB_LIM);
    idx      = dest_in[IDX_W-1:0];
    sel_cnt  = dest_ok ? cnt_arr[idx] : '0;
    vec_ok   = vec_in < sel_cnt;
    fire     = wr_ring && dest_ok && vec_ok;
    pulse_d  = fire;
    hold_en  = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_pulse <= 1'b0;
    end else begin
      ring_pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_dest <= '0;
      ring_vec  <= '0;
    end else if (hold_en) begin
      ring_dest <= dest_in;
      ring_vec  <= vec_in;
    end
  end

  AST_RING_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ring_pulse |-> $past(wr_ring)); // R9

  AST_RING_DEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ring_pulse |-> ({1'b0, ring_dest} < CMP_W'($past(peer_cnt)))); // R8

endmodule

// File: rtl/dbell_regs.sv
module dbell_regs
  import dbell_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int DEST_W    = 16,
  parameter int VEC_W     = 8,
  parameter int ID_W      = 16,
  parameter int EVT_W     = 8,
  parameter int PCNT_W    = $clog2(NUM_PEERS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       irq,
  input  logic                       evt_valid,
  input  logic [EVT_W-1:0]           evt_byte,
  input  logic                       shm_mapped,
  input  logic [ID_W-1:0]            node_id,
  input  logic [PCNT_W-1:0]          peer_cnt,
  input  logic [NUM_PEERS*VEC_W-1:0] vec_cnt,
  output logic                       ring_pulse,
  output logic [DEST_W-1:0]          ring_dest,
  output logic [VEC_W-1:0]           ring_vec
);

  localparam int DEST_LSB = DATA_W - DEST_W;
  localparam int ID_PAD   = DATA_W - ID_W;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta;
  logic rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  acc_t    acc;
  rd_sel_e rd_sel;

  dbell_decode u_decode (
    .wr     (bus_wr),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .acc    (acc),
    .rd_sel (rd_sel)
  );

  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] stat_q;

  dbell_irq #(.EVT_W(EVT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_mask   (acc.wr_mask),
    .wr_stat   (acc.wr_stat),
    .rd_stat   (acc.rd_stat),
    .wdata     (bus_wdata),
    .evt_valid (evt_valid),
    .evt_byte  (evt_byte),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .irq       (irq)
  );

  dbell_ring #(
    .NUM_PEERS (NUM_PEERS),
    .DEST_W    (DEST_W),
    .VEC_W     (VEC_W),
    .PCNT_W    (PCNT_W)
  ) u_ring (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wr_ring    (acc.wr_ring),
    .dest_in    (bus_wdata[DATA_W-1:DEST_LSB]),
    .vec_in     (bus_wdata[VEC_W-1:0]),
    .peer_cnt   (peer_cnt),
    .vec_cnt    (vec_cnt),
    .ring_pulse (ring_pulse),
    .ring_dest  (ring_dest),
    .ring_vec   (ring_vec)
  );

  logic [DATA_W-1:0] pos_word;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rdata_en;

  always_comb begin
    pos_word = shm_mapped ? {{ID_PAD{1'b0}}, node_id} : '1;
    rdata_en = bus_rd;
    unique case (rd_sel)
      SEL_MASK: rdata_d = mask_q;
      SEL_STAT: rdata_d = stat_q;
      SEL_POS:  rdata_d = pos_word;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !bus_rd |=> $stable(bus_rdata)); // R12

  AST_RDATA_STATUS: assert property (@(posedge clk) disable iff (!rst_sn)
    acc.rd_stat |=> (bus_rdata == $past(stat_q))); // R4

endmodule

// File: tb/dbell_regs_test.sv
module dbell_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_byte = '0;
  logic        shm_mapped = 1'b1;
  logic [15:0] node_id = 16'h0007;
  logic [2:0]  peer_cnt = 3'd3;
  // peer0:4 peer1:2 peer2:0 peer3:5
  logic [31:0] vec_cnt = {8'd5, 8'd0, 8'd2, 8'd4};
  logic        ring_pulse;
  logic [15:0] ring_dest;
  logic [7:0]  ring_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbell_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .evt_valid(evt_valid), .evt_byte(evt_byte),
    .shm_mapped(shm_mapped), .node_id(node_id), .peer_cnt(peer_cnt),
    .vec_cnt(vec_cnt), .ring_pulse(ring_pulse), .ring_dest(ring_dest),
    .ring_vec(ring_vec)
  );

  // {is_read, addr, wdata, expected read data}
  localparam int NV = 12;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'hFFFF0000, 32'h0},
    {1'b1, 8'h00, 32'h0,        32'hFFFF0000},
    {1'b0, 8'h03, 32'h12345678, 32'h0},
    {1'b1, 8'h00, 32'h0,        32'h12345678},
    {1'b0, 8'h04, 32'hA5A5A5A5, 32'h0},
    {1'b1, 8'h06, 32'h0,        32'hA5A5A5A5},
    {1'b1, 8'h04, 32'h0,        32'h00000000},
    {1'b1, 8'h10, 32'h0,        32'h00000000},
    {1'b1, 8'hFC, 32'h0,        32'h00000000},
    {1'b0, 8'h08, 32'h0000DEAD, 32'h0},
    {1'b0, 8'h20, 32'h00000001, 32'h0},
    {1'b1, 8'h00, 32'h0,        32'h12345678}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic ring(input logic [31:0] d, input bit exp_fire,
                      input logic [15:0] ed, input logic [7:0] ev, input string req);
    do_wr(8'h0C, d);
    chk(req, {31'b0, ring_pulse}, {31'b0, exp_fire});
    if (exp_fire) begin
      chk(req, {16'b0, ring_dest}, {16'b0, ed});
      chk(req, {24'b0, ring_vec}, {24'b0, ev});
    end
    @(negedge clk);
    chk(req, {31'b0, ring_pulse}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pulse", {31'b0, ring_pulse}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    do_rd(8'h00, v); chk("R1 mask", v, 32'h0);
    do_rd(8'h04, v); chk("R1 status", v, 32'h0);

    // table walk: R2 R4 R5 R11 R12
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        do_rd(VEC[i][71:64], v);
        chk($sformatf("R2/R4/R5/R11 vector %0d", i), v, VEC[i][31:0]);
      end else begin
        do_wr(VEC[i][71:64], VEC[i][63:32]);
      end
    end

    // R12 read data holds with no read
    repeat (3) @(negedge clk);
    chk("R12 hold", bus_rdata, 32'h12345678);

    // R3 interrupt level
    do_wr(8'h00, 32'h00000010);
    do_wr(8'h04, 32'h0000000F);
    chk("R3 no overlap", {31'b0, irq}, 32'h0);
    do_wr(8'h04, 32'h00000010);
    chk("R3 overlap", {31'b0, irq}, 32'h1);
    do_wr(8'h00, 32'h0);
    chk("R3 masked", {31'b0, irq}, 32'h0);
    do_wr(8'h00, 32'h00000010);
    chk("R3 unmasked", {31'b0, irq}, 32'h1);
    do_rd(8'h04, v);
    chk("R4 read value", v, 32'h00000010);
    chk("R4 irq drops", {31'b0, irq}, 32'h0);

    // R6 event alone, event vs read, event vs write
    @(negedge clk); evt_valid = 1'b1; evt_byte = 8'h81;
    @(negedge clk); evt_valid = 1'b0;
    do_rd(8'h04, v); chk("R6 event load", v, 32'h00000081);
    do_wr(8'h04, 32'h000000F0);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h04; evt_valid = 1'b1; evt_byte = 8'h3C;
    @(negedge clk);
    bus_rd = 1'b0; evt_valid = 1'b0;
    chk("R6 read returns old", bus_rdata, 32'h000000F0);
    do_rd(8'h04, v); chk("R6 event survives clear", v, 32'h0000003C);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'hFFFFFFFF;
    evt_valid = 1'b1; evt_byte = 8'h22;
    @(negedge clk);
    bus_wr = 1'b0; evt_valid = 1'b0;
    do_rd(8'h04, v); chk("R6 event beats write", v, 32'h00000022);

    // R7 position
    do_rd(8'h08, v); chk("R7 mapped", v, 32'h00000007);
    shm_mapped = 1'b0;
    do_rd(8'h08, v); chk("R7 unmapped", v, 32'hFFFFFFFF);
    shm_mapped = 1'b1;

    // R8 R9 R10 doorbells
    ring(32'h00000003, 1'b1, 16'h0000, 8'h03, "R9 valid ring");
    ring(32'h0001AB01, 1'b1, 16'h0001, 8'h01, "R9 bits 15:8 ignored");
    ring(32'h00010002, 1'b0, 16'h0, 8'h0, "R10 vector at limit");
    ring(32'h00020000, 1'b0, 16'h0, 8'h0, "R10 empty peer");
    ring(32'h00030000, 1'b0, 16'h0, 8'h0, "R8 dest at peer count");
    ring(32'h01000000, 1'b0, 16'h0, 8'h0, "R8 dest far out");
    peer_cnt = 3'd7;
    ring(32'h00040000, 1'b0, 16'h0, 8'h0, "R8 dest beyond table");
    ring(32'h00030004, 1'b1, 16'h0003, 8'h04, "R9 last peer");
    chk("R9 dest held", {16'b0, ring_dest}, 32'h00000003);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule